// File: doc/BRIEF.md
# Free-Running Timer with Compare-Clear

This block is an up-counting 16-bit time base. Capture and compare channels elsewhere in the chip share its live count. The count moves only on cycles where the count-enable input is high.

The overflow flag is set by either of two events:
- the count wraps from all ones back to zero, or
- clear mode is on and the count equals a programmable compare-clear value. In that case the counter restarts from zero instead of incrementing.

When the flag is set and its interrupt enable is on, the block drives a registered, level-type interrupt request.

Software reaches the block through a simple register port with one address bit:
- Address 0 is the control/status word.
- Address 1 is the compare-clear value.

Reads are combinational on the selected address. Writes take effect at the clock edge.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is 0x0000, the compare-clear register reads 0xFFFF, the control/status word reads 0x0000 and the interrupt request is low.
- R2: The count advances by one at each clock edge where the count-enable input is high, and holds its value on every other cycle.
- R3: A count-enable cycle with the count at 0xFFFF loads 0x0000 and sets the overflow flag (control bit 7). Until that cycle the flag stays 0.
- R4: With clear mode on (control bit 5 = 1), a count-enable cycle where the count equals the compare-clear value loads 0x0000 and sets the overflow flag. With clear mode off, a match has no effect on the count or the flag.
- R5: Writing the control word with bit 7 = 0 clears the overflow flag. Writing it with bit 7 = 1 leaves the flag unchanged.
- R6: If a flag-setting event and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R7: The interrupt request equals (overflow flag AND enable bit 6) as they were one cycle earlier. It rises one cycle after the flag sets, and falls one cycle after the flag or the enable is cleared.
- R8: Control bits 6 (interrupt enable) and 5 (clear mode) take the written value. All other control bits read 0. The compare-clear register reads back the last value written to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control/status, 1 compare-clear |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register |
| count_o | output | 16 | Live count value |
| irq_o | output | 1 | Overflow interrupt request (level) |

## Verification
A count register that is off by one, or that drops a count-enable cycle, shows up on count_o at the next clock edge. It also moves the wrap or match point, so the flag sets one cycle early or late and the control read-back disagrees at that point. A wrong flag-update priority appears only in the cycle where a clearing write meets a set event, so that collision is driven directly and read back at once. A missing or extra register stage on the interrupt path puts irq_o one cycle off its expected edge, which is checked in both directions.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned MODE_BIT = 5;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_CMP  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_mode_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] count_o,
  output logic         evt_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] count_q;
  logic         match_clr;
  logic         wrap;

  assign match_clr = clr_mode_i && (count_q == cmp_i);
  assign wrap      = (count_q == ALL_ONES);
  assign evt_o     = tick_i && (match_clr || wrap);
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (tick_i) begin
      if (match_clr)    count_q <= '0;
      else              count_q <= count_q + 1'b1;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q));
  // R2
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !match_clr && !wrap) |=> (count_q == $past(count_q) + 1'b1));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wrap) |=> (count_q == '0));
  // R4
  match_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_mode_i && (count_q == cmp_i)) |=> (count_q == '0));
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic flag_wr_i,
  input  logic ie_wr_i,
  input  logic mode_wr_i,
  input  logic evt_i,
  output logic flag_o,
  output logic ie_o,
  output logic mode_o,
  output logic irq_o
);
  logic flag_q, ie_q, mode_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // set event beats a clearing write
      if (evt_i)                    flag_q <= 1'b1;
      else if (wr_i && !flag_wr_i)  flag_q <= 1'b0;
      if (wr_i) begin
        ie_q   <= ie_wr_i;
        mode_q <= mode_wr_i;
      end
      irq_q <= flag_q && ie_q;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_q);
  // R5
  keep_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && (!wr_i || flag_wr_i)) |=> flag_q);
  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && ie_q) |=> irq_q);
  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_q && ie_q) |=> !irq_q);
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] ctrl_word;
  logic             evt, flag, ie, mode, ctrl_wr;

  assign ctrl_wr = bus_we_i && (bus_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cmp_q <= '1;
    else if (bus_we_i && bus_addr_i == REG_CMP)  cmp_q <= bus_wdata_i;
  end

  frt_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .clr_mode_i (mode),
    .cmp_i      (cmp_q),
    .count_o    (count_o),
    .evt_o      (evt)
  );

  frt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .flag_wr_i (bus_wdata_i[FLAG_BIT]),
    .ie_wr_i   (bus_wdata_i[IE_BIT]),
    .mode_wr_i (bus_wdata_i[MODE_BIT]),
    .evt_i     (evt),
    .flag_o    (flag),
    .ie_o      (ie),
    .mode_o    (mode),
    .irq_o     (irq_o)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[FLAG_BIT] = flag;
    ctrl_word[IE_BIT]   = ie;
    ctrl_word[MODE_BIT] = mode;
  end

  assign bus_rdata_o = (bus_addr_i == REG_CMP) ? cmp_q : ctrl_word;

  // R8
  cmp_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_CMP) |=> (cmp_q == $past(bus_wdata_i)));
endmodule

// File: tb/frt_timer_tb.sv
module frt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  frt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .count_o(count), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, input logic [15:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // one write cycle, optionally with tick high
  task automatic wr(input logic a, input logic [15:0] d, input logic t);
    we = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    rd(1'b0, 16'h0000, "R1 ctrl");
    rd(1'b1, 16'hFFFF, "R1 cmp");
    wr(1'b0, 16'hFFFF, 1'b0);
    rd(1'b0, 16'h0060, "R8 ctrl reserved bits");
    wr(1'b1, 16'h1234, 1'b0);
    rd(1'b1, 16'h1234, "R8 cmp readback");
    wr(1'b0, 16'h0000, 1'b0);
    rd(1'b0, 16'h0000, "R8 ctrl cleared");
  endtask

  task automatic t_count;
    ticks(10);
    chk("R2 ten ticks", count, 16'd10);
    repeat (5) @(negedge clk);
    chk("R2 hold", count, 16'd10);
  endtask

  task automatic t_clear_mode;
    wr(1'b1, 16'd20, 1'b0);
    wr(1'b0, 16'h0020, 1'b0);
    ticks(10);
    chk("R4 at match value", count, 16'd20);
    rd(1'b0, 16'h0020, "R4 flag not yet set");
    ticks(1);
    chk("R4 match reload", count, 16'd0);
    rd(1'b0, 16'h00A0, "R4 match sets flag");
    wr(1'b0, 16'h00A0, 1'b0);
    rd(1'b0, 16'h00A0, "R5 write 1 keeps flag");
    wr(1'b0, 16'h0020, 1'b0);
    rd(1'b0, 16'h0020, "R5 write 0 clears flag");
  endtask

  task automatic t_mode_off;
    wr(1'b0, 16'h0000, 1'b0);
    wr(1'b1, 16'd5, 1'b0);
    ticks(8);
    chk("R4 mode off passes match", count, 16'd8);
    rd(1'b0, 16'h0000, "R4 mode off no flag");
  endtask

  task automatic t_irq;
    wr(1'b1, 16'd10, 1'b0);
    wr(1'b0, 16'h0060, 1'b0);
    ticks(3);
    chk("R4 reload", count, 16'd0);
    rd(1'b0, 16'h00E0, "R7 flag set");
    chk("R7 irq one cycle late", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    chk("R7 irq raised", {15'b0, irq}, 16'h0001);
    wr(1'b0, 16'h0060, 1'b0);
    rd(1'b0, 16'h0060, "R5 flag cleared");
    chk("R7 irq still high", {15'b0, irq}, 16'h0001);
    @(negedge clk);
    chk("R7 irq dropped", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_collide;
    ticks(10);
    chk("R6 at match", count, 16'd10);
    wr(1'b0, 16'h0060, 1'b1);
    chk("R6 reload", count, 16'd0);
    rd(1'b0, 16'h00E0, "R6 set wins over clear");
  endtask

  task automatic t_wrap;
    wr(1'b0, 16'h0040, 1'b0);
    rd(1'b0, 16'h0040, "R3 flag clear before wrap");
    @(negedge clk);
    ticks(65535);
    chk("R3 at all ones", count, 16'hFFFF);
    rd(1'b0, 16'h0040, "R3 no flag before wrap");
    ticks(1);
    chk("R3 wrap to zero", count, 16'h0000);
    rd(1'b0, 16'h00C0, "R3 wrap sets flag");
    chk("R7 irq low at set", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    chk("R7 irq after wrap", {15'b0, irq}, 16'h0001);
    wr(1'b0, 16'h0080, 1'b0);
    @(negedge clk);
    chk("R7 irq drops on enable clear", {15'b0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_clear_mode();
    t_mode_off();
    t_irq();
    t_collide();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule